// File: doc/BRIEF.md
# Hill-Climbing Window Size Controller

This block chooses how many instruction-window bank groups one core keeps switched on. It works in rounds. A round first measures the size that is active now. It then measures half of that size, and after that twice that size. Each measurement lasts a fixed number of retired instructions. At the end of the round the controller keeps whichever size had the best energy-efficiency score. That size becomes the base for the next round, so the window climbs towards the size that suits the workload and stays there while it remains the best.

The score is cube throughput over power, which ranks the same way as energy times delay squared. Every measurement covers the same instruction count, so the block ranks candidates by the product of the cycle count squared and the summed energy, and the lowest product wins. No divider is needed. The energy input comes from an event-based power estimator and is added every cycle.

The size output changes only at the end of a measurement. A one-cycle request strobe tells the window logic to reconfigure. All inputs and outputs are plain per-cycle signals. There is no valid/ready handshake and nothing can apply back-pressure: the controller accepts a retire pulse and an energy value on every cycle, and the window logic must act on the strobe when it appears.

Top module: `hcw_size_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `group_count` equals INIT_GROUPS and `reconfig` is low.
- R2: A round measures the current size first, then `current/2` (rounded down), then `current*2`. A measurement ends on the cycle in which its SAMPLE_INSTRS-th retire pulse arrives. The next size appears on `group_count` in the following cycle and is otherwise held.
- R3: A halved size below MIN_GROUPS (or equal to zero) is skipped and not measured. A doubled size above MAX_GROUPS is skipped in the same way.
- R4: The score of a measurement is C*C*E. C counts every cycle from the first cycle of the measurement through its last retire cycle. E is the sum of `energy_inc` over those same cycles. The lowest score in a round becomes the next current size.
- R5: When scores are equal, the current size wins. Between the halved and the doubled size, the halved (smaller) one wins.
- R6: `reconfig` is high for exactly one cycle, on the cycle in which `group_count` takes a different value, and is low at all other times.
- R7: The cycle and energy totals start from zero at the start of each measurement, so nothing carries over from one measurement to the next.
- R8: The cycle total saturates at 2^CYC_W-1 and the energy total saturates at 2^EACC_W-1. A measurement in which either total reaches its ceiling gets the worst possible score.
- R9: `group_count` always lies between MIN_GROUPS and MAX_GROUPS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | 1 | One instruction retired this cycle |
| energy_inc | input | ENERGY_W | Energy spent this cycle |
| group_count | output | $clog2(MAX_GROUPS+1) | Number of active bank groups |
| reconfig | output | 1 | One-cycle request to resize the window |

## Verification
Each result of this block is due on the cycle right after the clock edge that takes a measurement's final retire pulse. On that cycle the new size and the strobe both appear, and the next measurement begins with its totals at zero. The bench drives inputs on falling edges and reads the outputs on those same falling edges before it drives again. The cycle in which it reads a new size is therefore exactly one register stage after the last retire. It also checks on every other cycle of a measurement that the size holds and the strobe stays low. The expected score of each measurement is computed from the counts of cycles and energy that the bench itself drove.

// File: rtl/hcw_pkg.sv
package hcw_pkg;
  typedef enum logic [1:0] {
    PH_CUR  = 2'd0,
    PH_HALF = 2'd1,
    PH_DBL  = 2'd2
  } phase_e;
endpackage

// File: rtl/hcw_sample_acc.sv
module hcw_sample_acc #(
  parameter int SAMPLE_INSTRS = 1000000,
  parameter int CYC_W         = 24,
  parameter int ENERGY_W      = 12,
  parameter int EACC_W        = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                retire,
  input  logic [ENERGY_W-1:0] energy_inc,
  output logic                done,
  output logic [CYC_W-1:0]    cyc_tot,
  output logic [EACC_W-1:0]   en_tot,
  output logic                sat
);
  localparam int IW = (SAMPLE_INSTRS > 1) ? $clog2(SAMPLE_INSTRS) : 1;
  localparam logic [IW-1:0] LAST = IW'(SAMPLE_INSTRS - 1);

  logic [IW-1:0]     instr_q;
  logic [CYC_W-1:0]  cyc_q, cyc_nx;
  logic [EACC_W-1:0] en_q, en_nx;
  logic [EACC_W:0]   en_sum;

  always_comb begin
    cyc_nx  = (cyc_q == '1) ? cyc_q : cyc_q + CYC_W'(1);
    en_sum  = {1'b0, en_q} + (EACC_W+1)'(energy_inc);
    en_nx   = en_sum[EACC_W] ? '1 : en_sum[EACC_W-1:0];
    done    = retire && (instr_q == LAST);
    cyc_tot = cyc_nx;
    en_tot  = en_nx;
    sat     = (cyc_nx == '1) || (en_nx == '1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || done) begin
      instr_q <= '0;
      cyc_q   <= '0;
      en_q    <= '0;
    end else begin
      instr_q <= instr_q + IW'(retire);
      cyc_q   <= cyc_nx;
      en_q    <= en_nx;
    end
  end

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cyc_q == '0 && en_q == '0 && instr_q == '0));

  p_cyc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == '1 && !done) |=> (cyc_q == '1));

  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '1 && !done) |=> (en_q == '1));
endmodule

// File: rtl/hcw_score.sv
module hcw_score #(
  parameter int CYC_W  = 24,
  parameter int EACC_W = 32,
  localparam int SW    = 2*CYC_W + EACC_W
) (
  input  logic [CYC_W-1:0]  cyc_tot,
  input  logic [EACC_W-1:0] en_tot,
  input  logic              sat,
  output logic [SW-1:0]     score
);
  always_comb begin
    if (sat) score = '1;
    else     score = SW'(cyc_tot) * SW'(cyc_tot) * SW'(en_tot);
  end
endmodule

// File: rtl/hcw_size_fsm.sv
module hcw_size_fsm
  import hcw_pkg::*;
#(
  parameter int MIN_GROUPS  = 1,
  parameter int MAX_GROUPS  = 16,
  parameter int INIT_GROUPS = 4,
  parameter int SW          = 80
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             done,
  input  logic [SW-1:0]                    score,
  output logic [$clog2(MAX_GROUPS+1)-1:0]  group_count,
  output logic                             reconfig
);
  localparam int GW = $clog2(MAX_GROUPS+1);
  localparam logic [GW:0]   MIN_L  = (GW+1)'(MIN_GROUPS);
  localparam logic [GW:0]   MAX_L  = (GW+1)'(MAX_GROUPS);
  localparam logic [GW-1:0] INIT_G = GW'(INIT_GROUPS);

  phase_e        phase_q, phase_d;
  logic [GW-1:0] cur_q, cur_d, trial_q, trial_d, best_q, best_d;
  logic [SW-1:0] bscore_q, bscore_d;
  logic          strobe_q;
  logic [GW:0]   half_w, dbl_w;
  logic          half_ok, dbl_ok, better;

  always_comb begin
    half_w  = {1'b0, cur_q} >> 1;
    dbl_w   = {cur_q, 1'b0};
    half_ok = (half_w != '0) && (half_w >= MIN_L);
    dbl_ok  = (dbl_w <= MAX_L);
    better  = (score < bscore_q);
  end

  always_comb begin
    phase_d  = phase_q;
    cur_d    = cur_q;
    trial_d  = trial_q;
    best_d   = best_q;
    bscore_d = bscore_q;
    if (done) begin
      case (phase_q)
        PH_CUR: begin
          best_d   = cur_q;
          bscore_d = score;
          if (half_ok) begin
            phase_d = PH_HALF;
            trial_d = half_w[GW-1:0];
          end else if (dbl_ok) begin
            phase_d = PH_DBL;
            trial_d = dbl_w[GW-1:0];
          end else begin
            trial_d = cur_q;
          end
        end
        PH_HALF: begin
          if (better) begin
            best_d   = half_w[GW-1:0];
            bscore_d = score;
          end
          if (dbl_ok) begin
            phase_d = PH_DBL;
            trial_d = dbl_w[GW-1:0];
          end else begin
            phase_d = PH_CUR;
            cur_d   = best_d;
            trial_d = best_d;
          end
        end
        PH_DBL: begin
          if (better) begin
            best_d   = dbl_w[GW-1:0];
            bscore_d = score;
          end
          phase_d = PH_CUR;
          cur_d   = best_d;
          trial_d = best_d;
        end
        default: begin
          phase_d = PH_CUR;
          trial_d = cur_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_CUR;
      cur_q    <= INIT_G;
      trial_q  <= INIT_G;
      best_q   <= INIT_G;
      bscore_q <= '1;
      strobe_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cur_q    <= cur_d;
      trial_q  <= trial_d;
      best_q   <= best_d;
      bscore_q <= bscore_d;
      strobe_q <= (trial_d != trial_q);
    end
  end

  assign group_count = trial_q;
  assign reconfig    = strobe_q;

  p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, trial_q} >= MIN_L) && ({1'b0, trial_q} <= MAX_L));

  p_strobe_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig |-> (trial_q != $past(trial_q)));

  p_change_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_q != $past(trial_q)) |-> reconfig);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done) |-> $stable(trial_q));

  p_half_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) == PH_CUR && phase_q == PH_HALF) |-> (trial_q == ($past(cur_q) >> 1)));
endmodule

// File: rtl/hcw_size_ctrl.sv
module hcw_size_ctrl #(
  parameter int SAMPLE_INSTRS = 1000000,
  parameter int MIN_GROUPS    = 1,
  parameter int MAX_GROUPS    = 16,
  parameter int INIT_GROUPS   = 4,
  parameter int CYC_W         = 24,
  parameter int ENERGY_W      = 12,
  parameter int EACC_W        = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            retire,
  input  logic [ENERGY_W-1:0]             energy_inc,
  output logic [$clog2(MAX_GROUPS+1)-1:0] group_count,
  output logic                            reconfig
);
  localparam int SW = 2*CYC_W + EACC_W;

  logic              done, sat;
  logic [CYC_W-1:0]  cyc_tot;
  logic [EACC_W-1:0] en_tot;
  logic [SW-1:0]     score;

  hcw_sample_acc #(
    .SAMPLE_INSTRS(SAMPLE_INSTRS), .CYC_W(CYC_W),
    .ENERGY_W(ENERGY_W), .EACC_W(EACC_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .retire(retire), .energy_inc(energy_inc),
    .done(done), .cyc_tot(cyc_tot), .en_tot(en_tot), .sat(sat)
  );

  hcw_score #(.CYC_W(CYC_W), .EACC_W(EACC_W)) u_score (
    .cyc_tot(cyc_tot), .en_tot(en_tot), .sat(sat), .score(score)
  );

  hcw_size_fsm #(
    .MIN_GROUPS(MIN_GROUPS), .MAX_GROUPS(MAX_GROUPS),
    .INIT_GROUPS(INIT_GROUPS), .SW(SW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .done(done), .score(score),
    .group_count(group_count), .reconfig(reconfig)
  );
endmodule

// File: tb/tb_hcw_size_ctrl.sv
module tb_hcw_size_ctrl;
  localparam int N     = 4;
  localparam int MINS  = 1;
  localparam int MAXS  = 8;
  localparam int INITS = 2;
  localparam int CMAX  = 63;
  localparam int EMAX  = 255;
  localparam longint SMAX = (64'd1 << 20) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       retire = 1'b0;
  logic [3:0] energy_inc = '0;
  logic [3:0] group_count;
  logic       reconfig;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int exp_cur = INITS;
  int prev_g = INITS;

  always #2 clk = ~clk;

  hcw_size_ctrl #(
    .SAMPLE_INSTRS(N), .MIN_GROUPS(MINS), .MAX_GROUPS(MAXS), .INIT_GROUPS(INITS),
    .CYC_W(6), .ENERGY_W(4), .EACC_W(8)
  ) dut (
    .clk(clk), .rst_n(rst_n), .retire(retire), .energy_inc(energy_inc),
    .group_count(group_count), .reconfig(reconfig)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pick_gap(int mode, int s, int cur);
    case (mode)
      0: return 8 / s - 1;
      4: return (s == cur) ? 15 : ((s < cur) ? 4 : 0);
      5: return 15;
      default: return 0;
    endcase
  endfunction

  function automatic int pick_e(int mode, int s, int cur);
    case (mode)
      0: return s;
      1: return s;
      2: return 3;
      3: return (s == cur) ? 5 : 2;
      4: return (s == cur) ? 1 : 15;
      default: return 1;
    endcase
  endfunction

  function automatic longint exp_score(int c, int en);
    if (c >= CMAX || en >= EMAX) return SMAX;
    return longint'(c) * c * en;
  endfunction

  task automatic run_sample(input int trial, input int gap, input int e);
    chk(group_count == 4'(trial), "R2 R3 trial size", int'(group_count), trial);
    chk(reconfig == (trial != prev_g), "R6 strobe at change", int'(reconfig), int'(trial != prev_g));
    prev_g = trial;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j <= gap; j++) begin
        if (!(i == 0 && j == 0)) begin
          @(negedge clk);
          chk(reconfig == 1'b0, "R6 strobe single cycle", int'(reconfig), 0);
          chk(group_count == 4'(trial), "R2 size held", int'(group_count), trial);
        end
        retire = (j == gap);
        energy_inc = 4'(e);
      end
    end
    @(negedge clk);
    retire = 1'b0;
    energy_inc = '0;
  endtask

  task automatic run_round(input int mode);
    int cur;
    int best;
    longint bsc;
    longint sc;
    int g;
    int e;
    cur = exp_cur;
    g = pick_gap(mode, cur, cur);
    e = pick_e(mode, cur, cur);
    run_sample(cur, g, e);
    best = cur;
    bsc = exp_score(N * (g + 1), e * N * (g + 1));
    if (cur / 2 >= MINS && cur / 2 != 0) begin
      g = pick_gap(mode, cur / 2, cur);
      e = pick_e(mode, cur / 2, cur);
      run_sample(cur / 2, g, e);
      sc = exp_score(N * (g + 1), e * N * (g + 1));
      if (sc < bsc) begin bsc = sc; best = cur / 2; end
    end
    if (cur * 2 <= MAXS) begin
      g = pick_gap(mode, cur * 2, cur);
      e = pick_e(mode, cur * 2, cur);
      run_sample(cur * 2, g, e);
      sc = exp_score(N * (g + 1), e * N * (g + 1));
      if (sc < bsc) begin bsc = sc; best = cur * 2; end
    end
    chk(group_count == 4'(best), "R4 R5 R7 R8 round winner", int'(group_count), best);
    exp_cur = best;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(group_count == 4'(INITS), "R1 size in reset", int'(group_count), INITS);
    chk(reconfig == 1'b0, "R1 strobe in reset", int'(reconfig), 0);
    rst_n = 1'b1;
    // grow to the upper bound (R3 skips 16), shrink to 1 (R3 skips 0),
    // ties (R5), saturation (R8)
    run_round(0); run_round(0); run_round(0);
    run_round(1); run_round(1); run_round(1); run_round(1);
    run_round(2);
    run_round(0);
    run_round(3);
    run_round(0);
    run_round(4);
    run_round(5);
    chk(group_count == 4'(exp_cur), "R9 final size", int'(group_count), exp_cur);
    chk(reconfig == (exp_cur != prev_g), "R6 final strobe", int'(reconfig), int'(exp_cur != prev_g));
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule